// File: doc/BRIEF.md
# Accumulator and Temporary Accumulator Pair

This block keeps the two working registers of an 8-bit processor that can also operate on 16-bit quantities: the accumulator and a temporary accumulator behind it. Loading a value into the accumulator pushes the accumulator's previous contents into the temporary register. A word load moves all 16 bits. A byte load moves only the low byte and keeps the upper bytes of both registers. The block also adds the two registers with a carry-in and writes the sum back into the accumulator. It does this either over the full word or over the low byte only. In both cases the carry-out goes to a carry register.

Requests arrive as a stream beat on a valid/ready pair. A beat is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. The block accepts at most one request per clock. `req_ready` is low while reset is asserted and high at all other times, so back-pressure exists only during reset. A sender may hold `req_valid` high with the beat unchanged until it is accepted. The register outputs are plain signals and change on the edge that accepts a beat.

Top module: `acc_pair`

## Requirements
- R1: While `rst_n` is low, the accumulator, the temporary accumulator and the carry all read 0, and `req_ready` is low.
- R2: An accepted word load (`req_op`=0, `req_word`=1) sets the accumulator to `req_data`. In the same edge it sets the temporary accumulator to the accumulator's previous 16-bit value.
- R3: An accepted byte load (`req_op`=0, `req_word`=0) has four effects. It writes `req_data[7:0]` into the accumulator's low byte and keeps the accumulator's upper byte. It copies the accumulator's previous low byte into the temporary accumulator's low byte and keeps the temporary accumulator's upper byte.
- R4: An accepted word add (`req_op`=1, `req_word`=1) sets the accumulator to the low 16 bits of A + T + `req_cin` and leaves T unchanged. For example, A=1234h, T=5678h and carry-in 1 give 68ADh.
- R5: An accepted byte add (`req_op`=1, `req_word`=0) sets the accumulator's low byte to the low 8 bits of A[7:0] + T[7:0] + `req_cin`. It leaves the accumulator's upper byte and all of T unchanged. For example, the operands of R4 give 12ADh.
- R6: After an add, `carry_out` is the carry out of bit 15 for a word add and out of bit 7 for a byte add. A load leaves `carry_out` unchanged.
- R7: `req_ready` is high whenever `rst_n` is high. In a cycle where no beat is accepted, A, T and `carry_out` hold their values.
- R8: The effect of an accepted beat is visible on the outputs right after the accepting clock edge, so back-to-back beats each see the result of the beat before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request beat present |
| req_ready | output | 1 | Block accepts a beat this cycle |
| req_op | input | 1 | 0 = load accumulator, 1 = add with carry |
| req_word | input | 1 | 1 = 16-bit operation, 0 = low byte only |
| req_data | input | 16 | Load value (low byte only used for byte loads) |
| req_cin | input | 1 | Carry-in for an add |
| acc_a | output | 16 | Accumulator |
| acc_t | output | 16 | Temporary accumulator |
| carry_out | output | 1 | Carry from the most recent add |

## Verification
Every state bit of this block is itself an output, so a wrong value in A, T or the carry is visible on the ports right after the edge that produced it. One kind of error stays hidden longer: a corrupted upper byte of T, or a wrongly kept upper byte of A. It appears only when a later word add or word load reads those bits. For that reason the stimulus chains byte operations into word operations and checks every register after every beat. Two more cases need targeted beats to show up. A carry leaking from the byte lane into the upper byte is caught by byte adds that overflow. A carry that loads wrongly disturb is caught by loads issued right after an add that produced a carry.

// File: rtl/acc_pair_pkg.sv
package acc_pair_pkg;
  typedef enum logic {
    OP_LOAD = 1'b0,
    OP_ADDC = 1'b1
  } acc_op_e;

  typedef struct packed {
    acc_op_e op;
    logic    word;
    logic    cin;
  } acc_ctl_t;
endpackage

// File: rtl/acc_load_unit.sv
module acc_load_unit #(
  parameter int WIDTH = 16,
  parameter int LANE  = 8
) (
  input  logic             word,
  input  logic [WIDTH-1:0] data,
  input  logic [WIDTH-1:0] cur_a,
  input  logic [WIDTH-1:0] cur_t,
  output logic [WIDTH-1:0] next_a,
  output logic [WIDTH-1:0] next_t
);
  localparam int UPPER = WIDTH - LANE;

  always_comb begin
    if (word) begin
      next_a = data;
      next_t = cur_a;
    end else begin
      next_a = {cur_a[WIDTH-1 -: UPPER], data[LANE-1:0]};
      next_t = {cur_t[WIDTH-1 -: UPPER], cur_a[LANE-1:0]};
    end
  end
endmodule

// File: rtl/acc_add_unit.sv
module acc_add_unit #(
  parameter int WIDTH = 16,
  parameter int LANE  = 8
) (
  input  logic             word,
  input  logic             cin,
  input  logic [WIDTH-1:0] cur_a,
  input  logic [WIDTH-1:0] cur_t,
  output logic [WIDTH-1:0] next_a,
  output logic             cout
);
  localparam int UPPER = WIDTH - LANE;

  logic [WIDTH:0] wide_sum;
  logic [LANE:0]  lane_sum;

  always_comb begin
    wide_sum = {1'b0, cur_a} + {1'b0, cur_t} + {{WIDTH{1'b0}}, cin};
    lane_sum = {1'b0, cur_a[LANE-1:0]} + {1'b0, cur_t[LANE-1:0]} + {{LANE{1'b0}}, cin};
    if (word) begin
      next_a = wide_sum[WIDTH-1:0];
      cout   = wide_sum[WIDTH];
    end else begin
      next_a = {cur_a[WIDTH-1 -: UPPER], lane_sum[LANE-1:0]};
      cout   = lane_sum[LANE];
    end
  end
endmodule

// File: rtl/acc_pair.sv
module acc_pair #(
  parameter int WIDTH = 16,
  parameter int LANE  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_op,
  input  logic             req_word,
  input  logic [WIDTH-1:0] req_data,
  input  logic             req_cin,
  output logic [WIDTH-1:0] acc_a,
  output logic [WIDTH-1:0] acc_t,
  output logic             carry_out
);
  import acc_pair_pkg::*;

  acc_ctl_t         ctl;
  logic             take;
  logic [WIDTH-1:0] ld_a, ld_t, add_a;
  logic             add_c;
  logic [WIDTH-1:0] a_q, t_q;
  logic             c_q;

  assign ctl       = '{op: acc_op_e'(req_op), word: req_word, cin: req_cin};
  assign req_ready = rst_n;
  assign take      = req_valid && req_ready;

  acc_load_unit #(.WIDTH(WIDTH), .LANE(LANE)) u_load (
    .word   (ctl.word),
    .data   (req_data),
    .cur_a  (a_q),
    .cur_t  (t_q),
    .next_a (ld_a),
    .next_t (ld_t)
  );

  acc_add_unit #(.WIDTH(WIDTH), .LANE(LANE)) u_add (
    .word   (ctl.word),
    .cin    (ctl.cin),
    .cur_a  (a_q),
    .cur_t  (t_q),
    .next_a (add_a),
    .cout   (add_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      t_q <= '0;
      c_q <= 1'b0;
    end else if (take) begin
      unique case (ctl.op)
        OP_LOAD: begin
          a_q <= ld_a;
          t_q <= ld_t;
        end
        OP_ADDC: begin
          a_q <= add_a;
          c_q <= add_c;
        end
        default: ;
      endcase
    end
  end

  assign acc_a     = a_q;
  assign acc_t     = t_q;
  assign carry_out = c_q;
endmodule

// File: rtl/acc_pair_chk.sv
module acc_pair_chk #(
  parameter int WIDTH = 16,
  parameter int LANE  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_op,
  input logic             req_word,
  input logic [WIDTH-1:0] req_data,
  input logic             req_cin,
  input logic [WIDTH-1:0] acc_a,
  input logic [WIDTH-1:0] acc_t,
  input logic             carry_out
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R1
  reset_ready_chk: assert property (@(posedge clk) !rst_n |-> !req_ready);

  // R7
  ready_up_chk: assert property (@(posedge clk) disable iff (!rst_n) req_ready);

  // R2
  word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_op && req_word) |=> (acc_a == $past(req_data) && acc_t == $past(acc_a)
                                      && carry_out == $past(carry_out)));

  // R3
  byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_op && !req_word) |=>
      (acc_a[LANE-1:0] == $past(req_data[LANE-1:0])
       && acc_a[WIDTH-1:LANE] == $past(acc_a[WIDTH-1:LANE])
       && acc_t[LANE-1:0] == $past(acc_a[LANE-1:0])
       && acc_t[WIDTH-1:LANE] == $past(acc_t[WIDTH-1:LANE])));

  // R4
  word_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op && req_word) |=>
      ({carry_out, acc_a} == {1'b0, $past(acc_a)} + {1'b0, $past(acc_t)} + (WIDTH+1)'($past(req_cin)))
      && $stable(acc_t));

  // R5
  byte_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_op && !req_word) |=>
      ({carry_out, acc_a[LANE-1:0]} == {1'b0, $past(acc_a[LANE-1:0])} + {1'b0, $past(acc_t[LANE-1:0])}
                                        + (LANE+1)'($past(req_cin)))
      && acc_a[WIDTH-1:LANE] == $past(acc_a[WIDTH-1:LANE]) && $stable(acc_t));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(acc_a) && $stable(acc_t) && $stable(carry_out)));
endmodule

bind acc_pair acc_pair_chk #(.WIDTH(WIDTH), .LANE(LANE)) u_chk (.*);

// File: tb/acc_pair_test.sv
module acc_pair_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic        req_word = 1'b0;
  logic [15:0] req_data = '0;
  logic        req_cin = 1'b0;
  logic [15:0] acc_a, acc_t;
  logic        carry_out;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  acc_pair uut (.*);

  // {vld, op, word, cin, data, expA, expT, expC}
  localparam int NV = 18;
  localparam logic [52:0] VEC [NV] = '{
    {1'b1,1'b0,1'b1,1'b0,16'h1234,16'h1234,16'h0000,1'b0}, // R2
    {1'b1,1'b0,1'b1,1'b0,16'h5678,16'h5678,16'h1234,1'b0}, // R2
    {1'b1,1'b0,1'b1,1'b0,16'h1234,16'h1234,16'h5678,1'b0}, // R2
    {1'b1,1'b1,1'b0,1'b1,16'h0000,16'h12AD,16'h5678,1'b0}, // R5
    {1'b1,1'b0,1'b1,1'b0,16'h1234,16'h1234,16'h12AD,1'b0}, // R2
    {1'b1,1'b0,1'b1,1'b0,16'h5678,16'h5678,16'h1234,1'b0}, // R2
    {1'b1,1'b0,1'b1,1'b0,16'h1234,16'h1234,16'h5678,1'b0}, // R2
    {1'b1,1'b1,1'b1,1'b1,16'h0000,16'h68AD,16'h5678,1'b0}, // R4
    {1'b1,1'b0,1'b0,1'b0,16'hAA9C,16'h689C,16'h56AD,1'b0}, // R3
    {1'b1,1'b1,1'b0,1'b0,16'h0000,16'h6849,16'h56AD,1'b1}, // R5 R6
    {1'b1,1'b0,1'b0,1'b0,16'h00FF,16'h68FF,16'h5649,1'b1}, // R3 R6
    {1'b1,1'b1,1'b0,1'b1,16'h0000,16'h6849,16'h5649,1'b1}, // R5 R6
    {1'b1,1'b0,1'b1,1'b0,16'hFFFF,16'hFFFF,16'h6849,1'b1}, // R2 R6
    {1'b1,1'b1,1'b1,1'b0,16'h0000,16'h6848,16'h6849,1'b1}, // R4 R6
    {1'b1,1'b1,1'b1,1'b1,16'h0000,16'hD092,16'h6849,1'b0}, // R4 R6
    {1'b1,1'b0,1'b1,1'b0,16'h0001,16'h0001,16'hD092,1'b0}, // R2
    {1'b1,1'b1,1'b0,1'b0,16'h0000,16'h0093,16'hD092,1'b0}, // R5
    {1'b0,1'b1,1'b1,1'b1,16'hBEEF,16'h0093,16'hD092,1'b0}  // R7
  };

  task automatic check(input string req, input logic [15:0] ea, input logic [15:0] et,
                       input logic ec);
    checks++;
    if (acc_a !== ea || acc_t !== et || carry_out !== ec) begin
      failures++;
      $display("FAIL %s: got A=%h T=%h C=%b expected A=%h T=%h C=%b",
               req, acc_a, acc_t, carry_out, ea, et, ec);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state and ready low in reset
    check("R1", 16'h0000, 16'h0000, 1'b0);
    check_bit("R1 ready", req_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R7 ready", req_ready, 1'b1);

    // R8: vectors walked back to back, each result sampled one edge later
    for (int i = 0; i < NV; i++) begin
      {req_valid, req_op, req_word, req_cin, req_data} = VEC[i][52:33];
      @(negedge clk);
      check($sformatf("R8 vec%0d", i), VEC[i][32:17], VEC[i][16:1], VEC[i][0]);
    end
    req_valid = 1'b0;

    // R7 several idle cycles with changing inputs hold state
    req_op = 1'b0; req_word = 1'b1; req_data = 16'h5555;
    repeat (3) @(negedge clk);
    check("R7 idle", 16'h0093, 16'hD092, 1'b0);

    // R6 carry from bit 7 only for byte add, upper byte of A untouched
    req_valid = 1'b1; req_op = 1'b0; req_word = 1'b1; req_data = 16'h7FFF;
    @(negedge clk);
    req_op = 1'b0; req_word = 1'b1; req_data = 16'h00FF;
    @(negedge clk); // A=00FF T=7FFF
    req_op = 1'b1; req_word = 1'b0; req_cin = 1'b1;
    @(negedge clk); // FF+FF+1=1FF
    check("R6 byte carry", 16'h00FF, 16'h7FFF, 1'b1);
    req_word = 1'b1; req_cin = 1'b0;
    @(negedge clk); // 00FF+7FFF=80FE
    check("R6 word no carry", 16'h80FE, 16'h7FFF, 1'b0);
    req_valid = 1'b0;

    // R1 reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset", 16'h0000, 16'h0000, 1'b0);
    check_bit("R1 ready mid", req_ready, 1'b0);
    req_valid = 1'b1; req_op = 1'b0; req_word = 1'b1; req_data = 16'h4321;
    @(negedge clk);
    check("R1 ignored in reset", 16'h0000, 16'h0000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 after reset", 16'h4321, 16'h0000, 1'b0);
    req_valid = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule